// File: doc/BRIEF.md
# Bunch-Crossing Window Gate Generator

This block produces, once per accelerator turn, a train of short timing windows that gate scalers so that each scaler counts only during its own bunch crossing or during its own gap between bunch trains. It runs on the bucket clock. A turn-marker pulse starts a sweep. A position counter is loaded with a programmable preset and runs up to a programmable terminal count. Moving the preset and terminal values shifts and bounds the sweep, so they can absorb cabling delay.

A slot sequencer steps through 54 window slots, arranged as 3 batches of 18. In each batch the first 12 slots sit on bunch crossings and the last 6 sit in the empty gap. Slots normally start `LONG_GAP` buckets apart. The one exception is the gap leading into the fifth empty slot of each batch, which is `SHORT_GAP` buckets long. For each slot, the gate output raises the matching bit of a one-hot vector for `GATE_W` buckets. An index output names the slot that is currently running.

Top module: `bunch_window_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, and afterwards until the first turn marker, `gate_o` is all zeros and `win_idx_o` is 0.
- R2: A turn marker sampled at an edge starts slot 0. `gate_o[0]` rises at the next rising edge, because the outputs lag the internal state by one register.
- R3: Consecutive slots start `LONG_GAP` buckets apart, except in the case covered by R4.
- R4: The gap into each slot whose position within its batch is 16 (0-based, i.e. the fifth empty slot of the batch) is `SHORT_GAP` buckets. With the defaults the in-batch gap sequence after the bunch slots is 21, 21, 21, 21, 14, 21.
- R5: The gate bit of a slot stays high for `GATE_W` consecutive buckets from the start of that slot, then stays low until the next slot starts.
- R6: At most one bit of `gate_o` is high at any time. When a bit is high, it is bit `win_idx_o`. While a sweep runs, `win_idx_o` holds the index of the current slot, including between gates. While idle it holds 0.
- R7: At the marker the position is loaded with `preset_i`. The sweep stops after the bucket in which the position equals or exceeds `terminal_i`. The states that run are therefore offsets 0 through max(0, terminal − preset) from the marker. After that, the outputs are idle.
- R8: When the full sequence completes, the sweep stops and the outputs stay idle until the next marker. Completion happens `LONG_GAP` buckets after slot 53 starts.
- R9: A marker that arrives during a running sweep restarts the position and the slot sequence at once, from slot 0.
- R10: A marker while idle starts a new sweep. If `preset_i` ≥ `terminal_i`, only the first bucket of slot 0 runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bucket clock |
| rst_n | input | 1 | Synchronous active-low reset |
| turn_mark | input | 1 | Once-per-turn start pulse, one clock wide |
| preset_i | input | POS_W | Position loaded at the turn marker |
| terminal_i | input | POS_W | Position at which the sweep ends |
| gate_o | output | NWIN (54) | Registered one-hot window gates |
| win_idx_o | output | clog2(NWIN) | Registered index of the running slot |

## Verification
The short gap lies deep in each batch, and the end of the sequence lies after 53 slots. Reaching both takes a full uninterrupted sweep with a terminal count beyond the sequence length. The bench therefore uses small gap values so that a whole turn fits in a few hundred cycles, and compares every cycle against slot start times that it computes by arithmetic. A marker that arrives mid-sweep is the hardest situation to bring about, because it needs a precisely placed second pulse while gates are active. The bench fires that second marker 40 buckets into a sweep and then follows the restarted sequence to its end.

// File: rtl/bwg_pkg.sv
// Shared helpers for the bunch window gate generator.
// Assumes slot indices are small non-negative integers.
package bwg_pkg;

    // True when the gap leading out of slot 'win' is the shortened one.
    function automatic bit gap_is_short(input int unsigned win,
                                        input int unsigned per_batch,
                                        input int unsigned short_pos);
        return ((win + 1) % per_batch) == short_pos;
    endfunction

endpackage

// File: rtl/bwg_sweep.sv
// Position counter for one turn sweep.
// The marker loads the preset and starts the sweep. The sweep stops after
// the bucket in which the position reaches the terminal count, or when the
// slot sequencer reports completion. Assumes turn_mark is one clock wide.
module bwg_sweep #(
    parameter int POS_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_mark,
    input  logic [POS_W-1:0] preset_i,
    input  logic [POS_W-1:0] terminal_i,
    input  logic             seq_done,
    output logic             sweep_on
);

    logic [POS_W-1:0] pos;

    // Load at the marker, count while running, stop at terminal or done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_on <= 1'b0;
            pos      <= '0;
        end else if (turn_mark) begin
            sweep_on <= 1'b1;
            pos      <= preset_i;
        end else if (sweep_on) begin
            if (pos >= terminal_i || seq_done) begin
                sweep_on <= 1'b0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

    // R7
    preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_mark |=> (sweep_on && pos == $past(preset_i)));

    // R7
    terminal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_on && !turn_mark && pos >= terminal_i) |=> !sweep_on);

endmodule

// File: rtl/bwg_slot_seq.sv
// Slot sequencer. It tracks the current window slot and the bucket offset
// inside that slot, and it steps to the next slot after a long or short gap.
// It reports completion in the last bucket of the final slot.
// Assumes SHORT_GAP and LONG_GAP are at least 1.
module bwg_slot_seq #(
    parameter int NWIN       = 54,
    parameter int PER_BATCH  = 18,
    parameter int SHORT_POS  = 16,
    parameter int LONG_GAP   = 21,
    parameter int SHORT_GAP  = 14,
    parameter int IDX_W      = 6,
    parameter int OFF_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_mark,
    input  logic             sweep_on,
    output logic [IDX_W-1:0] win,
    output logic [OFF_W-1:0] off,
    output logic             seq_done
);

    logic [NWIN-1:0]  short_mask;
    logic [OFF_W-1:0] gap_len;
    logic             last_slot;
    logic             slot_end;

    // Constant mask of slots whose outgoing gap is the short one.
    for (genvar g = 0; g < NWIN; g++) begin : g_mask
        assign short_mask[g] = bwg_pkg::gap_is_short(g, PER_BATCH, SHORT_POS);
    end

    // Gap length of the current slot and end-of-slot detection.
    always_comb begin
        gap_len   = short_mask[win] ? OFF_W'(SHORT_GAP) : OFF_W'(LONG_GAP);
        last_slot = (win == IDX_W'(NWIN - 1));
        slot_end  = (off == gap_len - OFF_W'(1));
        seq_done  = sweep_on && last_slot && slot_end;
    end

    // Restart on the marker, advance the offset and the slot while sweeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
            off <= '0;
        end else if (turn_mark) begin
            win <= '0;
            off <= '0;
        end else if (sweep_on) begin
            if (slot_end) begin
                off <= '0;
                if (!last_slot) win <= win + IDX_W'(1);
            end else begin
                off <= off + OFF_W'(1);
            end
        end
    end

    // R3
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_on && !turn_mark && slot_end && !last_slot)
            |=> (win == $past(win) + IDX_W'(1) && off == '0));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_mark |=> (win == '0 && off == '0));

endmodule

// File: rtl/bwg_gate_drv.sv
// Gate output stage. It decodes the running slot into a one-hot gate that
// is held for GATE_W buckets, and registers the gate and the slot index.
// Assumes GATE_W is no larger than SHORT_GAP.
module bwg_gate_drv #(
    parameter int NWIN   = 54,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 5,
    parameter int GATE_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sweep_on,
    input  logic [IDX_W-1:0] win,
    input  logic [OFF_W-1:0] off,
    output logic [NWIN-1:0]  gate_o,
    output logic [IDX_W-1:0] win_idx_o
);

    logic [NWIN-1:0] hot;
    logic            gate_open;

    // One decoder compare per slot.
    for (genvar g = 0; g < NWIN; g++) begin : g_dec
        assign hot[g] = (win == IDX_W'(g));
    end

    // Gate is open during the first GATE_W buckets of a running slot.
    always_comb gate_open = sweep_on && (off < OFF_W'(GATE_W));

    // Register the gate vector and the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o    <= '0;
            win_idx_o <= '0;
        end else begin
            gate_o    <= gate_open ? hot : '0;
            win_idx_o <= sweep_on ? win : '0;
        end
    end

    // R5
    gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off >= OFF_W'(GATE_W)) |=> (gate_o == '0));

endmodule

// File: rtl/bunch_window_gen.sv
// Bunch-crossing window gate generator, top level.
// A turn marker starts a sweep over NBATCH batches of slots. The first
// BUNCHES slots of a batch are on bunch crossings and the rest are empty.
// Each slot gets a GATE_W-bucket one-hot gate.
// Assumes GATE_W <= SHORT_GAP <= LONG_GAP and turn_mark is one clock wide.
module bunch_window_gen #(
    parameter int POS_W     = 10,
    parameter int NBATCH    = 3,
    parameter int BUNCHES   = 12,
    parameter int EMPTIES   = 6,
    parameter int SHORT_AT  = 4,
    parameter int LONG_GAP  = 21,
    parameter int SHORT_GAP = 14,
    parameter int GATE_W    = 1,
    localparam int PER_BATCH = BUNCHES + EMPTIES,
    localparam int NWIN      = NBATCH * PER_BATCH,
    localparam int IDX_W     = $clog2(NWIN),
    localparam int OFF_W     = $clog2(LONG_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             turn_mark,
    input  logic [POS_W-1:0] preset_i,
    input  logic [POS_W-1:0] terminal_i,
    output logic [NWIN-1:0]  gate_o,
    output logic [IDX_W-1:0] win_idx_o
);

    logic             sweep_on;
    logic             seq_done;
    logic [IDX_W-1:0] win;
    logic [OFF_W-1:0] off;

    bwg_sweep #(.POS_W(POS_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .turn_mark  (turn_mark),
        .preset_i   (preset_i),
        .terminal_i (terminal_i),
        .seq_done   (seq_done),
        .sweep_on   (sweep_on)
    );

    bwg_slot_seq #(
        .NWIN      (NWIN),
        .PER_BATCH (PER_BATCH),
        .SHORT_POS (BUNCHES + SHORT_AT),
        .LONG_GAP  (LONG_GAP),
        .SHORT_GAP (SHORT_GAP),
        .IDX_W     (IDX_W),
        .OFF_W     (OFF_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .turn_mark (turn_mark),
        .sweep_on  (sweep_on),
        .win       (win),
        .off       (off),
        .seq_done  (seq_done)
    );

    bwg_gate_drv #(
        .NWIN   (NWIN),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .GATE_W (GATE_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_on  (sweep_on),
        .win       (win),
        .off       (off),
        .gate_o    (gate_o),
        .win_idx_o (win_idx_o)
    );

    // R6
    one_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_o) && ((gate_o == '0) || gate_o[win_idx_o]));

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sweep_on |=> (gate_o == '0 && win_idx_o == '0));

    // R8
    done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !turn_mark) |=> !sweep_on);

endmodule

// File: tb/bunch_window_gen_bench.sv
module bunch_window_gen_bench;

    localparam int LG = 5, SG = 3, GW = 2, POS_W = 10;
    localparam int NB = 3, BUN = 12, EMP = 6, SAT = 4;
    localparam int PER = BUN + EMP, NWIN = NB * PER, SH = BUN + SAT;
    localparam int IDX_W = $clog2(NWIN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             turn_mark = 1'b0;
    logic [POS_W-1:0] preset = '0;
    logic [POS_W-1:0] terminal = '0;
    logic [NWIN-1:0]  gate_o;
    logic [IDX_W-1:0] win_idx_o;

    int checks = 0, errors = 0;
    int ks = -1, ko = -1, lim = 0;

    bunch_window_gen #(
        .POS_W(POS_W), .NBATCH(NB), .BUNCHES(BUN), .EMPTIES(EMP),
        .SHORT_AT(SAT), .LONG_GAP(LG), .SHORT_GAP(SG), .GATE_W(GW)
    ) u_bunch_window_gen (
        .clk(clk), .rst_n(rst_n), .turn_mark(turn_mark),
        .preset_i(preset), .terminal_i(terminal),
        .gate_o(gate_o), .win_idx_o(win_idx_o)
    );

    always #2 clk = ~clk;

    // Start offset of slot i: long gaps less the shortened ones before it (R3, R4).
    function automatic int start_of(int i);
        return i * LG - (LG - SG) * (i / PER + (((i % PER) >= SH) ? 1 : 0));
    endfunction

    // Last running offset for a given preset/terminal pair (R7, R8, R10).
    function automatic int lim_for(int p, int t);
        int a = (t > p) ? t - p : 0;
        int b = start_of(NWIN - 1) + LG - 1;
        return (a < b) ? a : b;
    endfunction

    task automatic check_out(string tag);
        logic [NWIN-1:0] eg = '0;
        int ei = 0;
        if (ko >= 0) begin
            for (int i = 0; i < NWIN; i++) if (start_of(i) <= ko) ei = i;
            if (ko - start_of(ei) < GW) eg[ei] = 1'b1;
        end
        checks++;
        if (gate_o !== eg) begin
            errors++;
            $display("FAIL %s gate: actual %h expected %h (offset %0d)", tag, gate_o, eg, ko);
        end
        checks++;
        if (int'(win_idx_o) != ei) begin
            errors++;
            $display("FAIL %s index: actual %0d expected %0d (offset %0d)", tag, win_idx_o, ei, ko);
        end
    endtask

    task automatic step(bit mark, string tag);
        @(negedge clk);
        check_out(tag);
        turn_mark = mark;
        if (mark) lim = lim_for(int'(preset), int'(terminal));
        ko = ks;
        ks = mark ? 0 : ((ks >= 0 && ks + 1 <= lim) ? ks + 1 : -1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R1");                           // R1: outputs held low in reset
        rst_n = 1'b1;
        repeat (5) step(1'b0, "R1");               // R1: idle before any marker

        preset = 10'd0; terminal = 10'd1000;       // full turn: R2 R3 R4 R5 R6 R8
        step(1'b1, "R2");
        repeat (275) step(1'b0, "R2 R3 R4 R5 R6 R8");

        preset = 10'd100; terminal = 10'd180;      // truncated sweep
        step(1'b1, "R7");
        repeat (100) step(1'b0, "R7");

        preset = 10'd0; terminal = 10'd1000;       // restart mid-sweep
        step(1'b1, "R9");
        repeat (40) step(1'b0, "R9");
        step(1'b1, "R9");
        repeat (275) step(1'b0, "R9 R8");

        preset = 10'd500; terminal = 10'd500;      // preset equals terminal
        step(1'b1, "R10");
        repeat (10) step(1'b0, "R10");
        preset = 10'd600; terminal = 10'd10;       // preset beyond terminal
        step(1'b1, "R10");
        repeat (10) step(1'b0, "R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule